// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt request lines into one request for the processor. Each line has its own mode word and its own vector word. The mode word sets a 3-bit priority and a trigger type: high level, low level, rising edge or falling edge. Software enables sources with a write-one-to-set command and disables them with a write-one-to-clear command. A readable mask word shows the enabled set, so software can save it and restore it later.

A read of the vector word acknowledges the current winner. The read returns that source's vector and pushes its priority onto an eight-entry nesting stack. The request output then stays quiet until a source of strictly higher priority appears. Each write to the end-of-interrupt word pops one stack level. A read made when no source can win returns a software-programmed spurious value and leaves the stack unchanged.

The register bus is a single-cycle synchronous interface. Writes take effect at the clock edge. Read data is combinational from the address, and any side effect of a read happens at the same edge.

Top module: `vpic_top`

## Requirements
- R1: A write to address 0x00 sets the mask bits that carry a 1, and a write to 0x01 clears them. Zero bits leave the mask as it was. A read of 0x02 returns the mask.
- R2: The mode word of source i sits at 0x40+i, with priority in bits [2:0] and trigger in bits [5:4]. The trigger codes are 0 high level, 1 rising, 2 low level and 3 falling. For sources below 24 (internal), bit 5 is forced to 0, so low becomes high and falling becomes rising. The read-back shows the stored value.
- R3: A level source is pending exactly while its input is at the active level (1 for high, 0 for low). It latches nothing.
- R4: An edge source latches pending on its selected edge. It stays pending after the input returns, and a vector read that acknowledges it clears it.
- R5: A write to 0x06 clears the latched edge state of each source whose bit is 1. An edge that arrives in the same cycle as that write still latches.
- R6: Among pending, enabled sources the winner has the highest priority (7 is the highest). A tie goes to the lower source number. A read of 0x03 returns the winner's vector word, held at 0x80+i.
- R7: irq_out is 1 exactly when a winner exists whose priority is strictly above the top of the stack, or the stack is empty and any winner exists.
- R8: A read of 0x03 while irq_out is 0 returns the spurious word (read/write at 0x05) and does not push.
- R9: A write to 0x04 pops one level. The stack holds eight levels, and a pop of an empty stack has no effect.
- R10: After reset the mask, the spurious word, every mode word and every vector word are 0, the stack is empty and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | 32 | Interrupt source lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: a source's edge detector can fire while a clear-edge command for that same source is being written. The bench raises the source line on the same falling clock edge that presents the clear write, so both meet at one rising edge. It then requires irq_out to be high and the next vector read to return that source's vector. Acknowledgement, edge latching and level tracking are also checked over a table of trigger types and input sequences, and nesting is walked to the full eight levels and unwound.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int N_SRC      = 32;
    localparam int PRIO_W     = 3;
    localparam int NEST_DEPTH = 8;
    localparam int VEC_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(N_SRC);
    localparam int SLOT_W     = $clog2(NEST_DEPTH);
    localparam int DEPTH_W    = $clog2(NEST_DEPTH + 1);
    localparam int RGN_W      = ADDR_W - IDX_W;

    localparam logic [ADDR_W-1:0] A_ENA_SET  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENA_CLR  = 8'h01;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h02;
    localparam logic [ADDR_W-1:0] A_VECTOR   = 8'h03;
    localparam logic [ADDR_W-1:0] A_EOI      = 8'h04;
    localparam logic [ADDR_W-1:0] A_SPUR     = 8'h05;
    localparam logic [ADDR_W-1:0] A_EDGE_CLR = 8'h06;
    localparam logic [ADDR_W-1:0] A_MODE_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] A_VEC_BASE  = 8'h80;

    localparam logic [RGN_W-1:0] RGN_MODE = A_MODE_BASE[ADDR_W-1:IDX_W];
    localparam logic [RGN_W-1:0] RGN_VEC  = A_VEC_BASE[ADDR_W-1:IDX_W];

    // trigger bit 0 selects edge, bit 1 selects inverted polarity
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_LOW  = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef struct packed {
        trig_e             trig;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    // internal sources may not use inverted polarity
    function automatic trig_e legal_trig(logic [1:0] req, logic is_ext);
        return is_ext ? trig_e'(req) : trig_e'({1'b0, req[0]});
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(src_cfg_t c);
        logic [DATA_W-1:0] d;
        d = '0;
        d[5:4] = c.trig;
        d[PRIO_W-1:0] = c.prio;
        return d;
    endfunction
endpackage

// File: rtl/vpic_srcbank.sv
module vpic_srcbank
    import vpic_pkg::*;
#(
    parameter int EXT_FIRST = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              vec_we,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              edge_clr_we,
    input  logic              ack,
    input  logic [IDX_W-1:0]  ack_idx,
    input  logic [N_SRC-1:0]  src_in,
    output src_cfg_t          cfg [N_SRC],
    output logic [VEC_W-1:0]  vec [N_SRC],
    output logic [N_SRC-1:0]  pending
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam logic IS_EXT = (g >= EXT_FIRST);
        src_cfg_t         cfg_q;
        logic [VEC_W-1:0] vec_q;
        logic             prev_q;
        logic             edge_q;
        logic             edge_hit;
        logic             edge_drop;

        always_comb begin
            edge_hit  = cfg_q.trig[0] &&
                        (cfg_q.trig[1] ? (prev_q && !src_in[g]) : (!prev_q && src_in[g]));
            edge_drop = (edge_clr_we && wdata[g]) || (ack && ack_idx == IDX_W'(g));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q  <= '{trig: TRIG_HIGH, prio: '0};
                vec_q  <= '0;
                prev_q <= 1'b0;
                edge_q <= 1'b0;
            end else begin
                prev_q <= src_in[g];
                edge_q <= edge_hit || (edge_q && !edge_drop);
                if (mode_we && sel_idx == IDX_W'(g)) begin
                    cfg_q.trig <= legal_trig(wdata[5:4], IS_EXT);
                    cfg_q.prio <= wdata[PRIO_W-1:0];
                end
                if (vec_we && sel_idx == IDX_W'(g))
                    vec_q <= wdata[VEC_W-1:0];
            end
        end

        assign cfg[g]     = cfg_q;
        assign vec[g]     = vec_q;
        assign pending[g] = cfg_q.trig[0] ? edge_q
                          : (cfg_q.trig[1] ? !src_in[g] : src_in[g]);
    end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
(
    input  logic [N_SRC-1:0]  cand,
    input  src_cfg_t          cfg [N_SRC],
    output logic              found,
    output logic [IDX_W-1:0]  best_idx,
    output logic [PRIO_W-1:0] best_prio
);
    // scanning downward with >= leaves the lowest index on ties
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!found || cfg[i].prio >= best_prio)) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = cfg[i].prio;
            end
        end
    end
endmodule

// File: rtl/vpic_nest_stack.sv
module vpic_nest_stack
    import vpic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [PRIO_W-1:0]  push_prio,
    input  logic               pop,
    output logic [DEPTH_W-1:0] depth,
    output logic               nonempty,
    output logic [PRIO_W-1:0]  top_prio
);
    logic [PRIO_W-1:0]  slot_q [NEST_DEPTH];
    logic [DEPTH_W-1:0] depth_q;
    logic [SLOT_W-1:0]  top_slot;
    logic               full;

    assign full     = (depth_q == DEPTH_W'(NEST_DEPTH));
    assign nonempty = (depth_q != '0);
    assign top_slot = SLOT_W'(depth_q - DEPTH_W'(1));
    assign top_prio = nonempty ? slot_q[top_slot] : '0;
    assign depth    = depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            for (int i = 0; i < NEST_DEPTH; i++) slot_q[i] <= '0;
        end else if (push && !full) begin
            slot_q[SLOT_W'(depth_q)] <= push_prio;
            depth_q <= depth_q + DEPTH_W'(1);
        end else if (pop && nonempty) begin
            depth_q <= depth_q - DEPTH_W'(1);
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int EXT_FIRST = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic              irq_out
);
    logic               wr, rd;
    logic [RGN_W-1:0]   rgn;
    logic [IDX_W-1:0]   idx;
    logic [N_SRC-1:0]   mask_q;
    logic [VEC_W-1:0]   spur_q;
    logic [N_SRC-1:0]   pending;
    logic [N_SRC-1:0]   cand;
    src_cfg_t           cfg [N_SRC];
    logic [VEC_W-1:0]   vec [N_SRC];
    logic               found;
    logic [IDX_W-1:0]   best_idx;
    logic [PRIO_W-1:0]  best_prio;
    logic [DEPTH_W-1:0] depth;
    logic               nonempty;
    logic [PRIO_W-1:0]  top_prio;
    logic               wins;
    logic               ack;
    logic               pop;

    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;
    assign rgn = bus_addr[ADDR_W-1:IDX_W];
    assign idx = bus_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            spur_q <= '0;
        end else if (wr) begin
            if (bus_addr == A_ENA_SET) mask_q <= mask_q | bus_wdata[N_SRC-1:0];
            if (bus_addr == A_ENA_CLR) mask_q <= mask_q & ~bus_wdata[N_SRC-1:0];
            if (bus_addr == A_SPUR)    spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    vpic_srcbank #(.EXT_FIRST(EXT_FIRST)) i_bank (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (wr && rgn == RGN_MODE),
        .vec_we     (wr && rgn == RGN_VEC),
        .sel_idx    (idx),
        .wdata      (bus_wdata),
        .edge_clr_we(wr && bus_addr == A_EDGE_CLR),
        .ack        (ack),
        .ack_idx    (best_idx),
        .src_in     (src_in),
        .cfg        (cfg),
        .vec        (vec),
        .pending    (pending)
    );

    assign cand = pending & mask_q;

    vpic_arbiter i_arb (
        .cand     (cand),
        .cfg      (cfg),
        .found    (found),
        .best_idx (best_idx),
        .best_prio(best_prio)
    );

    assign wins    = found && (!nonempty || best_prio > top_prio);
    assign irq_out = wins;
    assign ack     = rd && bus_addr == A_VECTOR && wins;
    assign pop     = wr && bus_addr == A_EOI;

    vpic_nest_stack i_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ack),
        .push_prio(best_prio),
        .pop      (pop),
        .depth    (depth),
        .nonempty (nonempty),
        .top_prio (top_prio)
    );

    always_comb begin
        bus_rdata = '0;
        if (rgn == RGN_MODE)
            bus_rdata = pack_mode(cfg[idx]);
        else if (rgn == RGN_VEC)
            bus_rdata = DATA_W'(vec[idx]);
        else begin
            case (bus_addr)
                A_MASK:   bus_rdata = DATA_W'(mask_q);
                A_VECTOR: bus_rdata = DATA_W'(wins ? vec[best_idx] : spur_q);
                A_SPUR:   bus_rdata = DATA_W'(spur_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
    import vpic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_out,
    input logic [N_SRC-1:0]   mask_q,
    input logic [VEC_W-1:0]   spur_q,
    input logic [N_SRC-1:0]   cand,
    input logic [DEPTH_W-1:0] depth
);
    logic vec_rd, eoi_wr, set_wr, clr_wr;
    assign vec_rd = bus_sel && !bus_we && bus_addr == A_VECTOR;
    assign eoi_wr = bus_sel && bus_we && bus_addr == A_EOI;
    assign set_wr = bus_sel && bus_we && bus_addr == A_ENA_SET;
    assign clr_wr = bus_sel && bus_we && bus_addr == A_ENA_CLR;

    AST_ENA_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]))); // R1
    AST_ENA_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == '0)); // R1
    AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (cand != '0)); // R7
    AST_SPUR_VALUE: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !irq_out) |-> (bus_rdata == DATA_W'(spur_q))); // R8
    AST_SPUR_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !irq_out) |=> (depth == $past(depth))); // R8
    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && irq_out) |=> (depth == $past(depth) + DEPTH_W'(1))); // R6
    AST_EOI_POPS: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && depth != '0) |=> (depth == $past(depth) - DEPTH_W'(1))); // R9
    AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && depth == '0) |=> (depth == '0)); // R9
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth <= DEPTH_W'(NEST_DEPTH)); // R9
endmodule

bind vpic_top vpic_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .mask_q   (mask_q),
    .spur_q   (spur_q),
    .cand     (cand),
    .depth    (depth)
);

// File: tb/test_vpic_top.sv
`timescale 1ns/1ps
module test_vpic_top;
    import vpic_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_SRC-1:0]  src_in = '0;
    logic              irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [31:0] SPUR = 32'h0000_DEAD;

    typedef struct packed {
        logic [4:0] src;
        logic [1:0] trig;
        logic       v0, v1, v2;
        logic       hit;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t TBL [NROWS] = '{
        '{5'd3,  2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{5'd3,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{5'd5,  2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{5'd5,  2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{5'd26, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        '{5'd26, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
        '{5'd27, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1},
        '{5'd27, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{5'd4,  2'd2, 1'b0, 1'b1, 1'b1, 1'b1},
        '{5'd4,  2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{5'd31, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    vpic_top i_vpic_top (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_in   (src_in),
        .irq_out  (irq_out)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_mode(int s, logic [1:0] t, logic [2:0] p);
        bus_write(A_MODE_BASE + ADDR_W'(s), {26'd0, t, 1'b0, p});
    endtask

    logic [31:0] d;

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R10 reset state
        check("R10 irq", {31'd0, irq_out}, 32'd0);
        bus_read(A_MASK, d);          check("R10 mask", d, 32'd0);
        bus_read(A_SPUR, d);          check("R10 spurious", d, 32'd0);
        bus_read(A_MODE_BASE + 8'd5, d); check("R10 mode", d, 32'd0);
        bus_read(A_VEC_BASE + 8'd7, d);  check("R10 vector word", d, 32'd0);
        bus_read(A_VECTOR, d);        check("R10 vector read", d, 32'd0);

        // R1 enable commands
        bus_write(A_ENA_SET, 32'h0000_00F0);
        bus_write(A_ENA_SET, 32'h0000_0300);
        bus_read(A_MASK, d);          check("R1 set accumulates", d, 32'h0000_03F0);
        bus_write(A_ENA_CLR, 32'h0000_0030);
        bus_read(A_MASK, d);          check("R1 clear selected", d, 32'h0000_03C0);
        bus_write(A_ENA_CLR, 32'hFFFF_FFFF);
        bus_read(A_MASK, d);          check("R1 clear all", d, 32'd0);

        // R2 trigger legality read-back
        set_mode(4, 2'd2, 3'd5);
        bus_read(A_MODE_BASE + 8'd4, d);  check("R2 internal low coerced", d, 32'h05);
        set_mode(26, 2'd2, 3'd6);
        bus_read(A_MODE_BASE + 8'd26, d); check("R2 external low kept", d, 32'h26);
        set_mode(4, 2'd0, 3'd0);
        set_mode(26, 2'd0, 3'd0);

        bus_write(A_SPUR, SPUR);
        for (int i = 0; i < N_SRC; i++)
            bus_write(A_VEC_BASE + ADDR_W'(i), 32'h100 + 32'(i));
        bus_read(A_VEC_BASE + 8'd9, d);   check("R6 vector word", d, 32'h109);

        // table walk: trigger types and input sequences
        for (int r = 0; r < NROWS; r++) begin
            row_t  e = TBL[r];
            string tag;
            if (e.src < 5'd24 && e.trig[1]) tag = "R2 coerced";
            else if (e.trig[0])             tag = "R4 edge";
            else                            tag = "R3 level";
            set_mode(int'(e.src), e.trig, 3'd2);
            src_in[e.src] = e.v0;
            wait_cyc(2);
            bus_write(A_EDGE_CLR, 32'd1 << e.src);
            bus_write(A_ENA_SET, 32'd1 << e.src);
            src_in[e.src] = e.v1;
            wait_cyc(2);
            src_in[e.src] = e.v2;
            wait_cyc(2);
            bus_read(A_VECTOR, d);
            check(tag, d, e.hit ? (32'h100 + 32'(e.src)) : SPUR);
            bus_write(A_ENA_CLR, 32'hFFFF_FFFF);
            if (e.hit) bus_write(A_EOI, 32'd0);
            src_in = '0;
            wait_cyc(2);
            bus_write(A_EDGE_CLR, 32'hFFFF_FFFF);
            set_mode(int'(e.src), 2'd0, 3'd0);
        end

        // R6 R7 R8 R9 arbitration and nesting
        set_mode(8, 2'd0, 3'd2);
        set_mode(9, 2'd0, 3'd5);
        set_mode(10, 2'd0, 3'd5);
        set_mode(11, 2'd0, 3'd7);
        bus_write(A_ENA_SET, 32'h0000_0F00);
        src_in[8] = 1'b1; src_in[9] = 1'b1; src_in[10] = 1'b1;
        wait_cyc(1);
        check("R7 request with empty stack", {31'd0, irq_out}, 32'd1);
        bus_read(A_VECTOR, d);  check("R6 tie to lower index", d, 32'h109);
        wait_cyc(1);
        check("R7 equal priority blocked", {31'd0, irq_out}, 32'd0);
        bus_read(A_VECTOR, d);  check("R8 spurious when blocked", d, SPUR);
        src_in[11] = 1'b1;
        wait_cyc(1);
        check("R7 higher priority preempts", {31'd0, irq_out}, 32'd1);
        bus_read(A_VECTOR, d);  check("R6 highest priority", d, 32'h10B);
        bus_write(A_EOI, 32'd0);
        wait_cyc(1);
        check("R9 pop one level", {31'd0, irq_out}, 32'd1);
        src_in[11] = 1'b0;
        wait_cyc(1);
        check("R3 level drop", {31'd0, irq_out}, 32'd0);
        bus_write(A_EOI, 32'd0);
        wait_cyc(1);
        check("R9 stack emptied", {31'd0, irq_out}, 32'd1);
        bus_read(A_VECTOR, d);  check("R6 reacknowledge", d, 32'h109);
        bus_write(A_EOI, 32'd0);
        bus_write(A_ENA_CLR, 32'hFFFF_FFFF);
        src_in = '0;

        // R9 full eight-level nesting
        for (int k = 0; k < NEST_DEPTH; k++) set_mode(16 + k, 2'd0, 3'(k));
        bus_write(A_ENA_SET, 32'h00FF_0000);
        for (int k = 0; k < NEST_DEPTH; k++) begin
            src_in[16 + k] = 1'b1;
            wait_cyc(1);
            bus_read(A_VECTOR, d);
            check("R9 nest push", d, 32'h110 + 32'(k));
        end
        check("R9 full stack quiet", {31'd0, irq_out}, 32'd0);
        bus_read(A_VECTOR, d);  check("R8 spurious at full", d, SPUR);
        src_in = '0;
        for (int k = 0; k < NEST_DEPTH - 1; k++) bus_write(A_EOI, 32'd0);
        src_in[16] = 1'b1;
        wait_cyc(1);
        check("R9 one level left", {31'd0, irq_out}, 32'd0);
        bus_write(A_EOI, 32'd0);
        wait_cyc(1);
        check("R9 eighth pop empties", {31'd0, irq_out}, 32'd1);
        bus_write(A_EOI, 32'd0);
        wait_cyc(1);
        check("R9 pop on empty harmless", {31'd0, irq_out}, 32'd1);
        bus_read(A_VECTOR, d);  check("R9 after empty pop", d, 32'h110);
        bus_write(A_EOI, 32'd0);
        bus_write(A_ENA_CLR, 32'hFFFF_FFFF);
        src_in = '0;

        // R4 R5 edge clear and same-cycle edge
        set_mode(12, 2'd1, 3'd3);
        bus_write(A_ENA_SET, 32'h0000_1000);
        src_in[12] = 1'b1; wait_cyc(1);
        src_in[12] = 1'b0; wait_cyc(2);
        check("R4 edge latched", {31'd0, irq_out}, 32'd1);
        bus_write(A_EDGE_CLR, 32'h0000_1000);
        wait_cyc(1);
        check("R5 clear command", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        src_in[12] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_EDGE_CLR; bus_wdata = 32'h0000_1000;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        wait_cyc(1);
        check("R5 edge wins over clear", {31'd0, irq_out}, 32'd1);
        bus_read(A_VECTOR, d);  check("R4 edge acknowledged", d, 32'h10C);
        bus_write(A_EOI, 32'd0);
        wait_cyc(1);
        check("R4 ack clears edge", {31'd0, irq_out}, 32'd0);
        src_in = '0;
        wait_cyc(2);

        finish_run();
    end
endmodule